// File: doc/BRIEF.md
# Display Shutdown and Protection Sequencer

This block runs the picture-tube shutdown when the deflection supply collapses, and it reacts to hardware faults. A digitized supply level is watched on every line tick. When the watch is enabled and the level falls below a trip point, the block blanks the RGB path at once, pushes the vertical deflection into overscan, and counts a fixed number of lines before it starts discharging the tube. During discharge the overscan value follows the supply level through one of three selectable relations. When the supply drops to a fifth of the level it had before the collapse, the block stops the horizontal drive and freezes the overscan value.

A separate protection path runs beside the sequence. It takes two fault flags: an overvoltage flag for the high-tension supply and a vertical-deflection failure flag. Either flag latches a sticky status bit and raises the protection output. Either flag also stops the horizontal drive in the same cycle, whatever the mode bits select. Software reads the status and pulses a read strobe, and that strobe clears the status bits.

Top module: `tube_shutdown_seq`

## Requirements
- R1: After reset, blankOut, dischargeOut, hdStop and protOut are 0, statusOut is 2'b00 and overscanOut is OVS_NORM (100).
- R2: With modeBits = 2'b00 the supply watch is off. A low supply level on line ticks leaves blankOut at 0 and overscanOut at OVS_NORM.
- R3: On a line tick with modeBits != 0 and supplyLevel < TRIP_LEVEL (128), blankOut is 1 from the next cycle onward and overscanOut is OVS_START (118). blankOut then stays 1 until reset.
- R4: dischargeOut rises after the DELAY_LINES-th (42nd) line tick that follows the start tick, and not after the 41st. Once high, it stays high until reset.
- R5: During discharge, one cycle after supplyLevel changes, overscanOut = min(255, 118 + (max(ref - level, 0) >> s)). Here s = 2, 1 or 0 for mode 2'b01, 2'b10 or 2'b11.
- R6: The relation is the one selected by modeBits on the start tick. Changes to modeBits after that tick have no effect.
- R7: On a line tick during discharge with 5*supplyLevel <= ref, hdStop goes to 1 and stays 1. overscanOut then keeps its last value, whatever supplyLevel does next.
- R8: ehtFault sets statusOut[0] and vDefFault sets statusOut[1], one cycle later. protOut is 1 while any status bit is 1.
- R9: hdStop is 1 in the same cycle that ehtFault or vDefFault is 1, in every mode and every sequence state.
- R10: Status bits stay set after their fault goes away. A statusRead pulse clears them. If a fault and statusRead arrive in the same cycle, the fault wins.
- R11: ref is the supplyLevel sampled on the last line tick before the start tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| lineTick | input | 1 | One-cycle pulse, once per video line |
| supplyLevel | input | LEVEL_W | Digitized deflection supply level |
| modeBits | input | 2 | 00 = watch off; 01/10/11 = overscan relation |
| ehtFault | input | 1 | High-tension overvoltage flag |
| vDefFault | input | 1 | Vertical deflection failure flag |
| statusRead | input | 1 | Status read strobe; clears the status bits |
| blankOut | output | 1 | Continuous RGB blanking |
| overscanOut | output | OVS_W | Vertical overscan command, in percent |
| dischargeOut | output | 1 | Tube discharge enable |
| hdStop | output | 1 | Horizontal drive stop |
| protOut | output | 1 | Protection output |
| statusOut | output | 2 | Sticky status: [0] overvoltage, [1] vertical failure |

## Verification
The bench builds the block with its defaults: an 8-bit level and overscan, a 42-line delay, a trip level of 128 and a halt divisor of 5. With these values the full delay can be counted tick by tick, so the bench checks that discharge does not start on line 41 and does start on line 42. An 8-bit overscan result lets mode 11 with a deep supply drop reach the 255 saturation. A reference level of 200 puts the halt boundary between level 41 (no halt) and level 40 (halt).

// File: rtl/bso_pkg.sv
package bso_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_BLANK = 2'd1,
    SEQ_DISCH = 2'd2,
    SEQ_HALT  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic refLoad;
    logic seqStart;
    logic lineCount;
    logic blankOn;
    logic dischOn;
    logic haltOn;
  } seqStrobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic tripLow;
    logic delayDone;
    logic lowPoint;
  } seqFlags_t;

endpackage

// File: rtl/bso_control.sv
module bso_control
  import bso_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineTick,
  input  logic [1:0] modeBits,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEQ_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      SEQ_IDLE: begin
        if (lineTick) begin
          if ((modeBits != 2'b00) && flags.tripLow) begin
            strobe.seqStart = 1'b1;
            stateD          = SEQ_BLANK;
          end else begin
            strobe.refLoad = 1'b1;
          end
        end
      end
      SEQ_BLANK: begin
        strobe.blankOn = 1'b1;
        if (lineTick) begin
          if (flags.delayDone) stateD = SEQ_DISCH;
          else                 strobe.lineCount = 1'b1;
        end
      end
      SEQ_DISCH: begin
        strobe.blankOn = 1'b1;
        strobe.dischOn = 1'b1;
        if (lineTick && flags.lowPoint) stateD = SEQ_HALT;
      end
      SEQ_HALT: begin
        strobe.blankOn = 1'b1;
        strobe.dischOn = 1'b1;
        strobe.haltOn  = 1'b1;
      end
      default: stateD = SEQ_IDLE;
    endcase
  end

endmodule

// File: rtl/bso_datapath.sv
module bso_datapath
  import bso_pkg::*;
#(
  parameter int LEVEL_W     = 8,
  parameter int OVS_W       = 8,
  parameter int DELAY_LINES = 42,
  parameter int TRIP_LEVEL  = 128,
  parameter int OVS_NORM    = 100,
  parameter int OVS_START   = 118,
  parameter int HALT_DIV    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] supplyLevel,
  input  logic [1:0]         modeBits,
  input  logic               ehtFault,
  input  logic               vDefFault,
  input  logic               statusRead,
  input  seqStrobe_t         strobe,
  output seqFlags_t          flags,
  output logic [OVS_W-1:0]   overscan,
  output logic [1:0]         status,
  output logic               protOut,
  output logic               hdStop
);

  localparam int CNT_W  = (DELAY_LINES > 1) ? $clog2(DELAY_LINES) : 1;
  localparam int PROD_W = LEVEL_W + $clog2(HALT_DIV + 1);
  localparam int SUM_W  = ((OVS_W > LEVEL_W) ? OVS_W : LEVEL_W) + 1;
  localparam logic [OVS_W-1:0] OVS_MAX = '1;
  localparam int NUM_REL = 3;

  logic [LEVEL_W-1:0] refLevel;
  logic [1:0]         modeLat;
  logic [CNT_W-1:0]   lineCnt;
  logic [OVS_W-1:0]   ovsHold;
  logic [1:0]         statusQ;

  // reference level tracks the healthy supply while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               refLevel <= '0;
    else if (strobe.refLoad) refLevel <= supplyLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                modeLat <= 2'b01;
    else if (strobe.seqStart) modeLat <= modeBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lineCnt <= '0;
    else if (strobe.seqStart)  lineCnt <= '0;
    else if (strobe.lineCount) lineCnt <= lineCnt + 1'b1;
  end

  // supply drop relative to reference, clamped at zero
  logic [LEVEL_W-1:0] dropV;
  assign dropV = (refLevel > supplyLevel) ? (refLevel - supplyLevel) : '0;

  // one saturating relation per selectable mode
  logic [OVS_W-1:0] relOvs [NUM_REL];
  for (genvar gi = 0; gi < NUM_REL; gi++) begin : g_rel
    localparam int SHIFT = NUM_REL - 1 - gi;
    logic [SUM_W-1:0] sumV;
    assign sumV = SUM_W'(OVS_START) + SUM_W'(dropV >> SHIFT);
    assign relOvs[gi] = (sumV > SUM_W'(OVS_MAX)) ? OVS_MAX : sumV[OVS_W-1:0];
  end

  logic [OVS_W-1:0] relSel;
  always_comb begin
    case (modeLat)
      2'b10:   relSel = relOvs[1];
      2'b11:   relSel = relOvs[2];
      default: relSel = relOvs[0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                ovsHold <= OVS_W'(OVS_START);
    else if (strobe.seqStart)                 ovsHold <= OVS_W'(OVS_START);
    else if (strobe.dischOn && !strobe.haltOn) ovsHold <= relSel;
  end

  assign overscan = strobe.blankOn ? ovsHold : OVS_W'(OVS_NORM);

  // sticky fault status, a new fault wins over a read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= 2'b00;
    else       statusQ <= (statusRead ? 2'b00 : statusQ) | {vDefFault, ehtFault};
  end

  assign status  = statusQ;
  assign protOut = |statusQ;
  assign hdStop  = strobe.haltOn | protOut | ehtFault | vDefFault;

  logic [PROD_W-1:0] scaledLevel;
  assign scaledLevel = PROD_W'(supplyLevel) * PROD_W'(HALT_DIV);

  assign flags.tripLow   = (supplyLevel < LEVEL_W'(TRIP_LEVEL));
  assign flags.delayDone = (lineCnt == CNT_W'(DELAY_LINES - 1));
  assign flags.lowPoint  = (scaledLevel <= PROD_W'(refLevel));

endmodule

// File: rtl/tube_shutdown_seq.sv
module tube_shutdown_seq
  import bso_pkg::*;
#(
  parameter int LEVEL_W     = 8,
  parameter int OVS_W       = 8,
  parameter int DELAY_LINES = 42,
  parameter int TRIP_LEVEL  = 128,
  parameter int OVS_NORM    = 100,
  parameter int OVS_START   = 118,
  parameter int HALT_DIV    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineTick,
  input  logic [LEVEL_W-1:0] supplyLevel,
  input  logic [1:0]         modeBits,
  input  logic               ehtFault,
  input  logic               vDefFault,
  input  logic               statusRead,
  output logic               blankOut,
  output logic [OVS_W-1:0]   overscanOut,
  output logic               dischargeOut,
  output logic               hdStop,
  output logic               protOut,
  output logic [1:0]         statusOut
);

  seqStrobe_t strobe;
  seqFlags_t  flags;

  bso_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineTick (lineTick),
    .modeBits (modeBits),
    .flags    (flags),
    .strobe   (strobe)
  );

  bso_datapath #(
    .LEVEL_W     (LEVEL_W),
    .OVS_W       (OVS_W),
    .DELAY_LINES (DELAY_LINES),
    .TRIP_LEVEL  (TRIP_LEVEL),
    .OVS_NORM    (OVS_NORM),
    .OVS_START   (OVS_START),
    .HALT_DIV    (HALT_DIV)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .supplyLevel (supplyLevel),
    .modeBits    (modeBits),
    .ehtFault    (ehtFault),
    .vDefFault   (vDefFault),
    .statusRead  (statusRead),
    .strobe      (strobe),
    .flags       (flags),
    .overscan    (overscanOut),
    .status      (statusOut),
    .protOut     (protOut),
    .hdStop      (hdStop)
  );

  assign blankOut     = strobe.blankOn;
  assign dischargeOut = strobe.dischOn;

endmodule

// File: rtl/tube_shutdown_seq_chk.sv
module tube_shutdown_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ehtFault,
  input logic       vDefFault,
  input logic       statusRead,
  input logic [1:0] modeBits,
  input logic       blankOut,
  input logic       dischargeOut,
  input logic       hdStop,
  input logic [1:0] statusOut
);

  p_watch_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == 2'b00 && !blankOut) |=> !blankOut);

  p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    blankOut |=> blankOut);

  p_disch_blanked_r4: assert property (@(posedge clk) disable iff (!rstN)
    dischargeOut |-> blankOut);

  p_disch_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    dischargeOut |=> dischargeOut);

  p_eht_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    ehtFault |=> statusOut[0]);

  p_vdef_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    vDefFault |=> statusOut[1]);

  p_fault_stops_hd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ehtFault || vDefFault) |-> hdStop);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !ehtFault && !vDefFault) |=> (statusOut == 2'b00));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[0] && !statusRead) |=> statusOut[0]);

endmodule

bind tube_shutdown_seq tube_shutdown_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ehtFault     (ehtFault),
  .vDefFault    (vDefFault),
  .statusRead   (statusRead),
  .modeBits     (modeBits),
  .blankOut     (blankOut),
  .dischargeOut (dischargeOut),
  .hdStop       (hdStop),
  .statusOut    (statusOut)
);

// File: tb/tb_tube_shutdown_seq.sv
`timescale 1ns/1ps
module tb_tube_shutdown_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineTick = 1'b0;
  logic [7:0] supplyLevel = 8'd0;
  logic [1:0] modeBits = 2'b00;
  logic       ehtFault = 1'b0;
  logic       vDefFault = 1'b0;
  logic       statusRead = 1'b0;
  logic       blankOut;
  logic [7:0] overscanOut;
  logic       dischargeOut;
  logic       hdStop;
  logic       protOut;
  logic [1:0] statusOut;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tube_shutdown_seq dut (
    .clk          (clk),
    .rstN         (rstN),
    .lineTick     (lineTick),
    .supplyLevel  (supplyLevel),
    .modeBits     (modeBits),
    .ehtFault     (ehtFault),
    .vDefFault    (vDefFault),
    .statusRead   (statusRead),
    .blankOut     (blankOut),
    .overscanOut  (overscanOut),
    .dischargeOut (dischargeOut),
    .hdStop       (hdStop),
    .protOut      (protOut),
    .statusOut    (statusOut)
  );

  // relation vectors: {mode, level, expected overscan}, reference level 200
  localparam logic [17:0] REL_VEC [6] = '{
    {2'd1, 8'd100, 8'd143},
    {2'd2, 8'd100, 8'd168},
    {2'd3, 8'd100, 8'd218},
    {2'd3, 8'd20,  8'd255},
    {2'd1, 8'd220, 8'd118},
    {2'd2, 8'd0,   8'd218}
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic line(input int n);
    for (int i = 0; i < n; i++) begin
      lineTick = 1'b1;
      step(1);
      lineTick = 1'b0;
      step(1);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    lineTick = 1'b0;
    ehtFault = 1'b0;
    vDefFault = 1'b0;
    statusRead = 1'b0;
    modeBits = 2'b00;
    supplyLevel = 8'd0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  // reference 200, start at level 100, run to discharge
  task automatic toDischarge(input logic [1:0] mode);
    doReset();
    modeBits = mode;
    supplyLevel = 8'd200;
    line(1);
    supplyLevel = 8'd100;
    line(1);
    line(42);
  endtask

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    check("R1 blank", blankOut, 0);
    check("R1 discharge", dischargeOut, 0);
    check("R1 hdStop", hdStop, 0);
    check("R1 prot", protOut, 0);
    check("R1 status", statusOut, 0);
    check("R1 overscan", overscanOut, 100);

    // R5 relation table
    for (int v = 0; v < 6; v++) begin
      toDischarge(REL_VEC[v][17:16]);
      check("R4 discharge on", dischargeOut, 1);
      supplyLevel = REL_VEC[v][15:8];
      step(2);
      check("R5 relation", overscanOut, REL_VEC[v][7:0]);
    end

    // R2 watch off, then R3 start once enabled
    doReset();
    supplyLevel = 8'd50;
    line(3);
    check("R2 no blank", blankOut, 0);
    check("R2 overscan", overscanOut, 100);
    modeBits = 2'b01;
    line(1);
    check("R3 blank", blankOut, 1);
    check("R3 overscan start", overscanOut, 118);

    // R4 exact delay
    doReset();
    modeBits = 2'b10;
    supplyLevel = 8'd200;
    line(1);
    supplyLevel = 8'd100;
    line(1);
    line(41);
    check("R4 not yet", dischargeOut, 0);
    check("R3 still 118", overscanOut, 118);
    line(1);
    check("R4 discharge", dischargeOut, 1);
    check("R3 blank held", blankOut, 1);

    // R6 mode latched at start
    doReset();
    modeBits = 2'b01;
    supplyLevel = 8'd200;
    line(1);
    supplyLevel = 8'd100;
    line(1);
    modeBits = 2'b11;
    line(42);
    step(2);
    check("R6 latched mode", overscanOut, 143);

    // R11 reference from last tick before start
    doReset();
    modeBits = 2'b11;
    supplyLevel = 8'd200;
    line(1);
    supplyLevel = 8'd160;
    line(1);
    supplyLevel = 8'd100;
    line(43);
    step(2);
    check("R11 reference", overscanOut, 178);

    // R7 halt boundary and freeze
    toDischarge(2'b01);
    supplyLevel = 8'd41;
    line(1);
    check("R7 no halt at 41", hdStop, 0);
    supplyLevel = 8'd40;
    line(1);
    check("R7 halt at 40", hdStop, 1);
    check("R7 overscan at halt", overscanOut, 158);
    supplyLevel = 8'd0;
    step(2);
    check("R7 frozen", overscanOut, 158);
    line(2);
    check("R7 halt held", hdStop, 1);

    // R8 R9 R10 protection path, watch off
    doReset();
    supplyLevel = 8'd200;
    ehtFault = 1'b1;
    #1;
    check("R9 immediate hd stop", hdStop, 1);
    step(1);
    check("R8 eht status", statusOut, 1);
    check("R8 prot", protOut, 1);
    ehtFault = 1'b0;
    step(2);
    check("R10 sticky", statusOut, 1);
    statusRead = 1'b1;
    step(1);
    statusRead = 1'b0;
    check("R10 cleared", statusOut, 0);
    check("R8 prot low", protOut, 0);
    check("R9 hd released", hdStop, 0);
    vDefFault = 1'b1;
    statusRead = 1'b1;
    step(1);
    vDefFault = 1'b0;
    statusRead = 1'b0;
    check("R10 set wins", statusOut, 2);
    check("R8 prot vdef", protOut, 1);

    // R9 during blanking, mode 10
    doReset();
    modeBits = 2'b10;
    supplyLevel = 8'd200;
    line(1);
    supplyLevel = 8'd100;
    line(3);
    check("R9 pre fault", hdStop, 0);
    vDefFault = 1'b1;
    #1;
    check("R9 fault in blank", hdStop, 1);
    vDefFault = 1'b0;
    step(1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule